// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block sits on the command side of an SDRAM controller. It takes one read request for a row that is already open, made up of bank, column, word count, CAS latency and an auto-precharge choice. It drives a READ onto the command pins and then, when fewer words are wanted than the programmed fixed burst length, cuts the burst short with a BURST TERMINATE. The terminate leaves the pins exactly `count` cycles after the READ. That places it CL-1 cycles ahead of the clock edge at which the last wanted word is valid, for either CAS latency.

The block counts the CAS latency itself and raises a data-valid strobe for each cycle in which DQ carries a wanted word. A one-cycle done pulse follows the last valid word. When auto precharge is requested, truncation is refused: no terminate is sent, and the whole programmed burst is delivered and flagged. A request with a zero word count, or with more words than the burst length, produces an error pulse and no command at all.

Top module: `sdram_rdtrunc_seq`

## Requirements
- R1: During and after synchronous reset, the command pins show NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1. Bank and address are zero, and rd_valid, done and err are low.
- R2: A request is accepted at the first rising edge where req_valid is high and the block is idle. In the cycle after that edge the pins show READ (cs_n=0, ras_n=1, cas_n=0, we_n=1). cmd_ba carries the bank, cmd_addr[COL_W-1:0] carries the column, cmd_addr[10] carries the auto-precharge choice, and all other address bits are 0.
- R3: When auto precharge is off and 1 <= count < BURST_LEN, exactly one BURST TERMINATE (cs_n=0, ras_n=1, cas_n=1, we_n=0) is driven, count cycles after the READ cycle. That is CL-1 cycles before the cycle in which the last wanted word is flagged, for CL 2 and CL 3.
- R4: When count equals BURST_LEN and auto precharge is off, no BURST TERMINATE is driven.
- R5: When auto precharge is on, no BURST TERMINATE is driven, and rd_valid is high for BURST_LEN cycles whatever the requested count.
- R6: rd_valid first goes high CL cycles after the READ cycle, where CL is 2 when req_cl3=0 and 3 when req_cl3=1. It then stays high for exactly the effective word count, without gaps.
- R7: done is high for exactly one cycle, the cycle right after the last rd_valid cycle.
- R8: Every command cycle other than the READ and BURST TERMINATE cycles carries NOP, with bank and address zero.
- R9: A request with count 0 or count > BURST_LEN raises err for one cycle, in the cycle after the accepting edge. It drives no READ or BURST TERMINATE and produces no rd_valid or done.
- R10: Requests are ignored while a read is in progress. A request held high through the done cycle is accepted at the edge that ends the done cycle, so its READ appears one cycle after done.
- R11: cmd_dqm stays low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_bank | input | BANK_W | Bank of the open row |
| req_col | input | COL_W | Starting column |
| req_count | input | clog2(BURST_LEN+1) | Number of words wanted |
| req_cl3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| req_autopre | input | 1 | Issue the READ with auto precharge |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | ADDR_W | Address bus |
| cmd_dqm | output | 1 | Data mask, held low |
| rd_valid | output | 1 | DQ carries a wanted read word this cycle |
| done | output | 1 | Read finished, one-cycle pulse |
| err | output | 1 | Request rejected, one-cycle pulse |

## Verification
The bench sweeps every word count from 0 to one past the burst length, for both latencies, with auto precharge on and off. A design that tied the terminate position to the latency rather than to the count would drop or add words at CL 3. One that always terminated would cut auto-precharge reads or full-length reads. The count boundaries at 0, BURST_LEN and BURST_LEN+1 catch an off-by-one in validation, which would issue a READ for an illegal request. A request held across an entire read shows whether the block wrongly accepts it while busy or misses the acceptance window at the done edge.

// File: rtl/rtq_pkg.sv
package rtq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_READ = 2'd1,
    CMD_BST  = 2'd2
  } rtq_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } rtq_pins_t;

  function automatic rtq_pins_t rtq_encode(input rtq_cmd_e c);
    rtq_pins_t p;
    case (c)
      CMD_READ: p = 4'b0101;
      CMD_BST:  p = 4'b0110;
      default:  p = 4'b0111;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rtq_req_check.sv
module rtq_req_check #(
  parameter int BURST_LEN = 8,
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic [CNT_W-1:0] count,
  input  logic             autopre,
  output logic             ok,
  output logic [CNT_W-1:0] eff_count,
  output logic             trunc
);

  localparam logic [CNT_W-1:0] BL_C = CNT_W'(BURST_LEN);

  always_comb begin
    ok        = (count != '0) && (count <= BL_C);
    eff_count = autopre ? BL_C : count;
    trunc     = !autopre && (count < BL_C);
  end

endmodule

// File: rtl/rtq_timeline.sv
module rtq_timeline #(
  parameter int BURST_LEN = 8,
  localparam int CNT_W  = $clog2(BURST_LEN + 1),
  localparam int TICK_W = $clog2(BURST_LEN + 5)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cl3,
  input  logic             trunc,
  output logic             busy,
  output logic             ev_bst,
  output logic             ev_valid,
  output logic             ev_done
);

  logic [TICK_W-1:0] tick_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cl3_q;
  logic              trunc_q;
  logic [TICK_W-1:0] tick_n;
  logic [TICK_W-1:0] lat;
  logic [TICK_W-1:0] end_tick;

  always_comb begin
    tick_n   = tick_q + 1'b1;
    lat      = cl3_q ? TICK_W'(3) : TICK_W'(2);
    end_tick = lat + TICK_W'(cnt_q);
    ev_bst   = busy && trunc_q && (tick_n == TICK_W'(cnt_q));
    ev_valid = busy && (tick_n >= lat) && (tick_n < end_tick);
    ev_done  = busy && (tick_n == end_tick);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      tick_q  <= '0;
      cnt_q   <= '0;
      cl3_q   <= 1'b0;
      trunc_q <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      tick_q  <= '0;
      cnt_q   <= cnt;
      cl3_q   <= cl3;
      trunc_q <= trunc;
    end else if (busy) begin
      tick_q <= tick_n;
      if (ev_done) busy <= 1'b0;
    end
  end

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy) else $error("start while busy");  // R10

  AST_BST_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
    ev_bst |-> !ev_done && busy) else $error("terminate outside read");  // R3

endmodule

// File: rtl/rtq_cmd_drive.sv
module rtq_cmd_drive
  import rtq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  rtq_cmd_e          cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              ap,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dqm
);

  logic              is_read;
  logic [ADDR_W-1:0] addr_d;
  rtq_pins_t         pins_d;

  assign is_read = (cmd == CMD_READ);
  assign pins_d  = rtq_encode(cmd);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
    if (i == AP_BIT) begin : g_ap
      assign addr_d[i] = is_read & ap;
    end else if (i < COL_W) begin : g_col
      assign addr_d[i] = is_read & col[i];
    end else begin : g_zero
      assign addr_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n  <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ba    <= '0;
      addr  <= '0;
      dqm   <= 1'b0;
    end else begin
      cs_n  <= pins_d.cs_n;
      ras_n <= pins_d.ras_n;
      cas_n <= pins_d.cas_n;
      we_n  <= pins_d.we_n;
      ba    <= is_read ? bank : '0;
      addr  <= addr_d;
      dqm   <= 1'b0;
    end
  end

  AST_NOP_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n && we_n) |-> (addr == '0 && ba == '0)) else $error("nop addr");  // R8

endmodule

// File: rtl/sdram_rdtrunc_seq.sv
module sdram_rdtrunc_seq
  import rtq_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 8,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_cl3,
  input  logic              req_autopre,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_dqm,
  output logic              rd_valid,
  output logic              done,
  output logic              err
);

  logic             busy;
  logic             accept;
  logic             ok;
  logic             trunc;
  logic             start;
  logic [CNT_W-1:0] eff_count;
  logic             ev_bst;
  logic             ev_valid;
  logic             ev_done;
  logic             ap_q;
  rtq_cmd_e         cmd_sel;

  assign accept = req_valid && !busy;
  assign start  = accept && ok;

  rtq_req_check #(.BURST_LEN(BURST_LEN)) i_check (
    .count     (req_count),
    .autopre   (req_autopre),
    .ok        (ok),
    .eff_count (eff_count),
    .trunc     (trunc)
  );

  rtq_timeline #(.BURST_LEN(BURST_LEN)) i_timeline (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cnt      (eff_count),
    .cl3      (req_cl3),
    .trunc    (trunc),
    .busy     (busy),
    .ev_bst   (ev_bst),
    .ev_valid (ev_valid),
    .ev_done  (ev_done)
  );

  always_comb begin
    if (start)       cmd_sel = CMD_READ;
    else if (ev_bst) cmd_sel = CMD_BST;
    else             cmd_sel = CMD_NOP;
  end

  rtq_cmd_drive #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
  ) i_drive (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd_sel),
    .bank  (req_bank),
    .col   (req_col),
    .ap    (req_autopre),
    .cs_n  (cmd_cs_n),
    .ras_n (cmd_ras_n),
    .cas_n (cmd_cas_n),
    .we_n  (cmd_we_n),
    .ba    (cmd_ba),
    .addr  (cmd_addr),
    .dqm   (cmd_dqm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      ap_q     <= 1'b0;
    end else begin
      rd_valid <= ev_valid;
      done     <= ev_done;
      err      <= accept && !ok;
      if (start) ap_q <= req_autopre;
    end
  end

  logic out_read;
  logic out_bst;
  logic out_nop;
  assign out_read = !cmd_cs_n && cmd_ras_n && !cmd_cas_n && cmd_we_n;
  assign out_bst  = !cmd_cs_n && cmd_ras_n && cmd_cas_n && !cmd_we_n;
  assign out_nop  = !cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n;

  AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    err |-> out_nop && !rd_valid && !done) else $error("cmd on err");  // R9

  AST_BST_NOT_AP: assert property (@(posedge clk) disable iff (rst)
    out_bst |-> !ap_q) else $error("terminate with auto precharge");  // R5

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> ($past(out_read, 2) || $past(out_read, 3))) else $error("latency");  // R6

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rd_valid) && !rd_valid) else $error("done placement");  // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done width");  // R7

endmodule

// File: tb/test_sdram_rdtrunc_seq.sv
module test_sdram_rdtrunc_seq;

  localparam int BL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_col = '0;
  logic [3:0]  req_count = '0;
  logic        req_cl3 = 1'b0;
  logic        req_autopre = 1'b0;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_dqm;
  logic [1:0]  cmd_ba;
  logic [11:0] cmd_addr;
  logic        rd_valid, done, err;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  sdram_rdtrunc_seq i_sdram_rdtrunc_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_col(req_col), .req_count(req_count), .req_cl3(req_cl3),
    .req_autopre(req_autopre), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba),
    .cmd_addr(cmd_addr), .cmd_dqm(cmd_dqm), .rd_valid(rd_valid),
    .done(done), .err(err)
  );

  task automatic chk(input bit pass, input string tag, input int act, input int exp);
    nchk++;
    if (!pass) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit is_read();
    return !cmd_cs_n && cmd_ras_n && !cmd_cas_n && cmd_we_n;
  endfunction
  function automatic bit is_bst();
    return !cmd_cs_n && cmd_ras_n && cmd_cas_n && !cmd_we_n;
  endfunction
  function automatic bit is_nop();
    return !cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n;
  endfunction

  task automatic run_one(input int b, input int c, input int cnt, input int cl3, input int ap);
    int eff, lat, win, exp_bst, exp_addr;
    bit ok, trunc;
    int rd_at, nreads, bst_at, nbst, vfirst, vcount, vlast, gap, done_at, ndone;
    int err_at, nerrp, badcmd, dqmhi, got_addr, got_ba;
    ok = (cnt >= 1) && (cnt <= BL);
    eff = ap ? BL : cnt;
    trunc = !ap && (cnt < BL);
    lat = cl3 ? 3 : 2;
    exp_bst = trunc ? cnt : -1;
    exp_addr = (c & 8'hFF) | (ap << 10);
    rd_at = -1; nreads = 0; bst_at = -1; nbst = 0; vfirst = -1; vcount = 0;
    vlast = -1; gap = 0; done_at = -1; ndone = 0; err_at = -1; nerrp = 0;
    badcmd = 0; dqmhi = 0; got_addr = -1; got_ba = -1;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(b); req_col = 8'(c); req_count = 4'(cnt);
    req_cl3 = cl3[0]; req_autopre = ap[0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    win = lat + BL + 3;
    for (int k = 0; k < win; k++) begin
      if (is_read()) begin
        nreads++;
        if (rd_at < 0) begin rd_at = k; got_addr = cmd_addr; got_ba = cmd_ba; end
      end else if (is_bst()) begin
        nbst++;
        if (bst_at < 0) bst_at = k;
      end else if (!is_nop() || cmd_addr != 0 || cmd_ba != 0) begin
        badcmd++;
      end
      if (rd_valid) begin
        if (vfirst < 0) vfirst = k;
        else if (vlast != k - 1) gap++;
        vlast = k;
        vcount++;
      end
      if (done) begin ndone++; if (done_at < 0) done_at = k; end
      if (err) begin nerrp++; if (err_at < 0) err_at = k; end
      if (cmd_dqm) dqmhi++;
      @(negedge clk);
    end
    chk(dqmhi == 0, "R11 dqm low", dqmhi, 0);
    if (ok) begin
      chk(rd_at == 0 && nreads == 1, "R2 read cycle", rd_at, 0);
      chk(got_addr == exp_addr, "R2 read address", got_addr, exp_addr);
      chk(got_ba == b, "R2 read bank", got_ba, b);
      if (ap) chk(nbst == 0, "R5 no terminate with auto precharge", nbst, 0);
      else if (cnt == BL) chk(nbst == 0, "R4 no terminate at full length", nbst, 0);
      else begin
        chk(bst_at == exp_bst && nbst == 1, "R3 terminate position", bst_at, exp_bst);
        chk(vlast - bst_at == lat - 1, "R3 terminate lead CL-1", vlast - bst_at, lat - 1);
      end
      chk(vfirst == lat, "R6 first valid at CL", vfirst, lat);
      if (ap) chk(vcount == BL, "R5 full burst flagged", vcount, BL);
      else chk(vcount == eff && gap == 0, "R6 valid word count", vcount, eff);
      chk(done_at == lat + eff && ndone == 1, "R7 done placement", done_at, lat + eff);
      chk(badcmd == 0, "R8 nop elsewhere", badcmd, 0);
      chk(nerrp == 0, "R9 no err on legal request", nerrp, 0);
    end else begin
      chk(nreads == 0 && nbst == 0, "R9 no command on bad count", nreads + nbst, 0);
      chk(vcount == 0 && ndone == 0, "R9 no data on bad count", vcount + ndone, 0);
      chk(err_at == 0 && nerrp == 1, "R9 err pulse", err_at, 0);
      chk(badcmd == 0, "R8 nop on rejected request", badcmd, 0);
    end
  endtask

  task automatic run_held();
    int reads[4];
    int banks[4];
    int nreads, vcount, ndone, done_at;
    nreads = 0; vcount = 0; ndone = 0; done_at = -1;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'd1; req_col = 8'd5; req_count = 4'd4;
    req_cl3 = 1'b1; req_autopre = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 26; k++) begin
      if (k == 1) req_bank = 2'd2;
      if (is_read()) begin
        if (nreads < 4) begin reads[nreads] = k; banks[nreads] = cmd_ba; end
        nreads++;
      end
      if (rd_valid) vcount++;
      if (done) begin ndone++; if (done_at < 0) done_at = k; end
      if (k == 8) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(nreads == 2, "R10 reads for held request", nreads, 2);
    chk(reads[0] == 0, "R10 first read", reads[0], 0);
    chk(reads[1] == 8, "R10 accept right after done", reads[1], 8);
    chk(banks[1] == 2, "R10 second read bank", banks[1], 2);
    chk(done_at == 7, "R10 first done", done_at, 7);
    chk(vcount == 8 && ndone == 2, "R10 busy request ignored", vcount, 8);
  endtask

  initial begin
    #(8 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(is_nop() && cmd_addr == 0 && cmd_ba == 0, "R1 reset command", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 7);
    chk(!rd_valid && !done && !err && !cmd_dqm, "R1 reset flags", {rd_valid, done, err, cmd_dqm}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(is_nop() && !rd_valid && !done && !err, "R1 idle after reset", {rd_valid, done, err}, 0);
    for (int cl = 0; cl < 2; cl++)
      for (int ap = 0; ap < 2; ap++)
        for (int n = 0; n <= BL + 1; n++)
          run_one(n % 4, (n * 37 + cl * 5) % 256, n, cl, ap);
    run_held();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule